// File: doc/BRIEF.md
# SIMD Increment, Negate and Bit-Locate Unit

This combinational execution unit works on a 64-bit operand split into equal lanes of 8, 16, 32 or 64 bits. In every lane at once it can add one, subtract one, negate, take the absolute value, or report the position of the lowest clear or lowest set bit. No carry chain is used. A shared locator finds, in each lane, the run of trailing ones and the first zero above it. An exclusive-OR with that run then produces the arithmetic result.

The operand is inverted at the input for the operations that need the lowest set bit instead of the lowest clear bit. The locator builds a per-lane flip mask with a logarithmic prefix-AND tree. One XOR level applies the mask. Two selection levels then choose the result for the opcode. For absolute value, the second level chooses lane by lane on each lane's sign bit. The result follows the inputs in the same cycle. No flags or traps are produced.

Top module: `simd_inc_unit`

## Requirements
- R1: Opcode 0 (increment) gives, in each lane, the lane value plus one modulo 2^lane width.
- R2: Opcode 1 (decrement) gives, in each lane, the lane value minus one modulo 2^lane width, so a zero lane becomes all ones.
- R3: Opcode 2 (negate) gives, in each lane, the two's complement of the lane value. A zero lane stays zero, and the most negative value maps to itself.
- R4: Opcode 3 (absolute value) negates a lane when its top bit is set and passes it unchanged otherwise.
- R5: Opcode 4 places in each lane, zero-extended, the index of the lowest 0 bit of that lane. A lane with no 0 bit returns all ones.
- R6: Opcode 5 places in each lane, zero-extended, the index of the lowest 1 bit of that lane. A lane with no 1 bit returns all ones.
- R7: The size input selects the lane width: 0 for 8, 1 for 16, 2 for 32 and 3 for 64 bits. No effect crosses a lane boundary.
- R8: Opcodes 6 and 7 produce an all-zero result.
- R9: The result is a pure function of the current inputs, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 64 | Operand, split into lanes |
| op_i | input | 3 | Opcode (0 inc, 1 dec, 2 neg, 3 abs, 4 lowest-zero index, 5 lowest-one index) |
| size_i | input | 2 | Lane width select (0:8, 1:16, 2:32, 3:64 bits) |
| res_o | output | 64 | Per-lane result |

## Verification
The only internal state is the flip mask, and it is combinational. If the mask tree merges across a lane boundary, increment of an all-ones lane breaks the next lane within the same cycle. If it stops too early, a long run of trailing ones leaves high bits unflipped. If the absolute-value select reads the wrong sign bit, every negative lane in a wide lane with a positive low byte is wrong at once. The sweep covers every byte value in each lane width. It also checks the all-zero, all-ones and most-negative corners, so each of these faults shows at the result port on the first vector that triggers it.

// File: rtl/simd_inc_pkg.sv
package simd_inc_pkg;
  typedef enum logic [2:0] {
    OP_INC  = 3'd0,
    OP_DEC  = 3'd1,
    OP_NEG  = 3'd2,
    OP_ABS  = 3'd3,
    OP_LSB0 = 3'd4,
    OP_LSB1 = 3'd5
  } simd_op_e;
endpackage

// File: rtl/simd_inc_prefix.sv
// Per-lane inclusive prefix AND (log-depth) and the flip mask derived from it.
module simd_inc_prefix #(
  parameter int DATA_W    = 64,
  parameter int MIN_CHUNK = 8,
  parameter int NUM_SIZES = 4,
  parameter int SZ_W      = 2
) (
  input  logic [DATA_W-1:0] vec_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic [DATA_W-1:0] pfx_o,
  output logic [DATA_W-1:0] flip_o
);
  logic [DATA_W-1:0] pfx_s  [NUM_SIZES];
  logic [DATA_W-1:0] flip_s [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int CW = MIN_CHUNK << s;
    localparam int LG = $clog2(CW);
    logic [DATA_W-1:0] pfx_g, flip_g;

    always_comb begin : tree
      logic [DATA_W-1:0] cur, nxt;
      cur = vec_i;
      for (int j = 0; j < LG; j++) begin
        nxt = cur;
        for (int i = 0; i < DATA_W; i++) begin
          if ((i % CW) >= (1 << j)) begin
            nxt[i] = cur[i] & cur[i - (1 << j)];
          end
        end
        cur = nxt;
      end
      pfx_g = cur;
    end

    always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
        if ((i % CW) == 0) flip_g[i] = 1'b1;
        else               flip_g[i] = pfx_g[i - 1];
      end
    end

    assign pfx_s[s]  = pfx_g;
    assign flip_s[s] = flip_g;
  end

  always_comb begin
    if (int'(size_i) < NUM_SIZES) begin
      pfx_o  = pfx_s[size_i];
      flip_o = flip_s[size_i];
    end else begin
      pfx_o  = pfx_s[NUM_SIZES-1];
      flip_o = flip_s[NUM_SIZES-1];
    end
  end
endmodule

// File: rtl/simd_inc_index.sv
// Turns the per-lane prefix into the index of the first zero (all ones if none).
module simd_inc_index #(
  parameter int DATA_W    = 64,
  parameter int MIN_CHUNK = 8,
  parameter int NUM_SIZES = 4,
  parameter int SZ_W      = 2
) (
  input  logic [DATA_W-1:0] pfx_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic [DATA_W-1:0] idx_o
);
  logic [DATA_W-1:0] idx_s [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int CW    = MIN_CHUNK << s;
    localparam int NLANE = DATA_W / CW;
    logic [DATA_W-1:0] idx_g;

    always_comb begin
      idx_g = '0;
      for (int c = 0; c < NLANE; c++) begin
        int cnt;
        cnt = 0;
        for (int b = 0; b < CW; b++) cnt += int'(pfx_i[c*CW + b]);
        if (pfx_i[c*CW + CW - 1]) idx_g[c*CW +: CW] = '1;
        else                      idx_g[c*CW +: CW] = CW'(cnt);
      end
    end

    assign idx_s[s] = idx_g;
  end

  always_comb begin
    if (int'(size_i) < NUM_SIZES) idx_o = idx_s[size_i];
    else                          idx_o = idx_s[NUM_SIZES-1];
  end
endmodule

// File: rtl/simd_inc_unit.sv
module simd_inc_unit #(
  parameter  int DATA_W    = 64,
  parameter  int MIN_CHUNK = 8,
  localparam int NUM_SIZES = $clog2(DATA_W / MIN_CHUNK) + 1,
  localparam int SZ_W      = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [2:0]        op_i,
  input  logic [SZ_W-1:0]   size_i,
  output logic [DATA_W-1:0] res_o
);
  import simd_inc_pkg::*;

  logic              inv;
  logic [DATA_W-1:0] loc_in, pfx, flip, flipped, arith, idx, sgn;
  logic [DATA_W-1:0] sgn_s [NUM_SIZES];

  // Level 1: invert when the lowest set bit is wanted.
  assign inv    = (op_i == OP_DEC) || (op_i == OP_NEG) ||
                  (op_i == OP_ABS) || (op_i == OP_LSB1);
  assign loc_in = inv ? ~opnd_i : opnd_i;

  simd_inc_prefix #(
    .DATA_W(DATA_W), .MIN_CHUNK(MIN_CHUNK), .NUM_SIZES(NUM_SIZES), .SZ_W(SZ_W)
  ) u_prefix (
    .vec_i (loc_in),
    .size_i(size_i),
    .pfx_o (pfx),
    .flip_o(flip)
  );

  simd_inc_index #(
    .DATA_W(DATA_W), .MIN_CHUNK(MIN_CHUNK), .NUM_SIZES(NUM_SIZES), .SZ_W(SZ_W)
  ) u_index (
    .pfx_i (pfx),
    .size_i(size_i),
    .idx_o (idx)
  );

  // Lane sign bit spread over every bit of the lane.
  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sign
    localparam int CW = MIN_CHUNK << s;
    logic [DATA_W-1:0] sg;
    always_comb begin
      for (int i = 0; i < DATA_W; i++) sg[i] = opnd_i[(i / CW) * CW + CW - 1];
    end
    assign sgn_s[s] = sg;
  end

  always_comb begin
    if (int'(size_i) < NUM_SIZES) sgn = sgn_s[size_i];
    else                          sgn = sgn_s[NUM_SIZES-1];
  end

  // XOR level and the two selection levels.
  assign flipped = loc_in ^ flip;
  assign arith   = (op_i == OP_DEC) ? (opnd_i ^ flip) : flipped;

  always_comb begin
    case (op_i)
      OP_INC, OP_DEC, OP_NEG: res_o = arith;
      OP_ABS:                 res_o = (arith & sgn) | (opnd_i & ~sgn);
      OP_LSB0, OP_LSB1:       res_o = idx;
      default:                res_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_inc_unit_chk.sv
module simd_inc_unit_chk #(
  parameter  int DATA_W    = 64,
  parameter  int MIN_CHUNK = 8,
  localparam int NUM_SIZES = $clog2(DATA_W / MIN_CHUNK) + 1,
  localparam int SZ_W      = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1
) (
  input logic [DATA_W-1:0] opnd_i,
  input logic [2:0]        op_i,
  input logic [SZ_W-1:0]   size_i,
  input logic [DATA_W-1:0] res_o
);
  localparam int NLANE_MIN = DATA_W / MIN_CHUNK;
  logic full, known, small_inc_ok;

  assign full  = (int'(size_i) == NUM_SIZES - 1);
  assign known = !$isunknown({opnd_i, op_i, size_i, res_o});

  always_comb begin
    small_inc_ok = 1'b1;
    for (int c = 0; c < NLANE_MIN; c++) begin
      if (res_o[c*MIN_CHUNK +: MIN_CHUNK] !=
          MIN_CHUNK'(opnd_i[c*MIN_CHUNK +: MIN_CHUNK] + 1'b1))
        small_inc_ok = 1'b0;
    end
  end

  always_comb begin
    if (known) begin
      if (full && op_i == 3'd0)
        AST_INC_FULL: assert (res_o == opnd_i + 1'b1);                      // R1
      if (full && op_i == 3'd1)
        AST_DEC_FULL: assert (res_o == opnd_i - 1'b1);                      // R2
      if (full && op_i == 3'd2)
        AST_NEG_FULL: assert (res_o + opnd_i == '0);                        // R3
      if (full && op_i == 3'd3)
        AST_ABS_FULL: assert (res_o == (opnd_i[DATA_W-1] ? -opnd_i : opnd_i)); // R4
      if (full && op_i == 3'd4 && opnd_i == '1)
        AST_LSB0_NONE: assert (res_o == '1);                                // R5
      if (full && op_i == 3'd5 && opnd_i == '0)
        AST_LSB1_NONE: assert (res_o == '1);                                // R6
      if (int'(size_i) == 0 && op_i == 3'd0)
        AST_LANE_ISOLATE: assert (small_inc_ok);                            // R7
      if (op_i > 3'd5)
        AST_UNDEF_ZERO: assert (res_o == '0);                               // R8
    end
  end
endmodule

bind simd_inc_unit simd_inc_unit_chk #(.DATA_W(DATA_W), .MIN_CHUNK(MIN_CHUNK)) u_chk (.*);

// File: tb/sim_simd_inc_unit.sv
`timescale 1ns/1ps
module sim_simd_inc_unit;
  logic        clk;
  logic [63:0] opnd;
  logic [2:0]  op;
  logic [1:0]  size;
  logic [63:0] res;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  simd_inc_unit u0 (.opnd_i(opnd), .op_i(op), .size_i(size), .res_o(res));

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [63:0] model(input logic [2:0] o, input int sz,
                                        input logic [63:0] x);
    int cw;
    logic [63:0] r, m, v, y;
    cw = 8 << sz;
    m  = (cw == 64) ? '1 : ((64'd1 << cw) - 64'd1);
    r  = '0;
    for (int c = 0; c < 64 / cw; c++) begin
      v = (x >> (c * cw)) & m;
      case (o)
        3'd0: y = v + 64'd1;
        3'd1: y = v - 64'd1;
        3'd2: y = 64'd0 - v;
        3'd3: y = v[cw-1] ? (64'd0 - v) : v;
        3'd4, 3'd5: begin
          int k;
          k = -1;
          for (int b = cw - 1; b >= 0; b--) if (v[b] == (o == 3'd5)) k = b;
          y = (k < 0) ? m : 64'(k);
        end
        default: y = '0;
      endcase
      r |= (y & m) << (c * cw);
    end
    return r;
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [2:0] o, input int sz, input logic [63:0] x,
                       input string tag);
    logic [63:0] exp;
    @(posedge clk);
    op = o; size = 2'(sz); opnd = x;
    exp = model(o, sz, x);
    @(negedge clk);
    n_tests++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d size=%0d opnd=%h actual=%h expected=%h",
               tag, o, sz, x, res, exp);
    end
  endtask

  initial begin
    logic [63:0] lcg;
    op = 3'd6; size = 2'd0; opnd = '1;
    apply(3'd6, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    apply(3'd7, 3, 64'h8000_0000_0000_0001, "R8");
    // R7: lane isolation corners
    apply(3'd0, 0, 64'h00FF_00FF_00FF_00FF, "R7");
    apply(3'd1, 1, 64'h0000_0001_0000_0000, "R7");
    apply(3'd2, 2, 64'h0000_0000_8000_0000, "R7");
    apply(3'd0, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    // R3/R4: zero and most negative lanes
    apply(3'd2, 3, 64'h0, "R3");
    apply(3'd3, 0, 64'h8080_8080_8080_8080, "R4");
    apply(3'd3, 1, 64'h8000_7FFF_FFFF_0001, "R4");
    // R5/R6: no such bit
    apply(3'd4, 2, 64'hFFFF_FFFF_0000_0000, "R5");
    apply(3'd5, 3, 64'h0, "R6");
    apply(3'd5, 3, 64'h8000_0000_0000_0000, "R6");
    // Sweep: every byte value in each lane width and opcode (R9: same-cycle result)
    lcg = 64'h1234_5678_9ABC_DEF1;
    for (int sz = 0; sz < 4; sz++) begin
      for (int o = 0; o < 8; o++) begin
        for (int v = 0; v < 256; v++) begin
          logic [63:0] x;
          lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
          case (v % 4)
            0: x = {8{8'(v)}};
            1: x = {lcg[63:8], 8'(v)};
            2: x = {8'(v), 56'h0} | (lcg & 64'h00FF_0000_0000_FF00);
            default: x = {8'(v), {7{8'hFF}}} ^ {lcg[31:0], 32'h0};
          endcase
          apply(3'(o), sz, x, req_of(3'(o)));
        end
      end
    end
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule